// File: doc/BRIEF.md
# Programmable Pulse Train Generator

This block drives three independent output bits. Each output is either a repeating serial bit pattern or a square wave. Every channel has three pieces of state. The first is a rate value that divides the system clock into advance steps. The second is a 5-bit mode value that picks square-wave output or a pattern length. The third is a 32-bit pattern word, sent least significant bit first. A global enable word starts and stops the channels. A separate write-one-to-clear word stops single channels without a read-modify-write of the enable word.

Software programs the block through a simple single-cycle write port: address, data and a write strobe. There is no read path. A channel starts cleanly from pattern bit 0 whenever its enable goes from 0 to 1. Pattern or mode updates made while a channel runs are held back until the running pattern wraps. This means a sequence is never cut part way through.

Top module: `pulse_train_gen`

## Requirements
- R1: After reset, all outputs are low and all channels are disabled. Each channel has mode 1 (square wave), rate 0 and pattern 0. A channel enabled without any configuration therefore drives a steady high level.
- R2: The write map is as follows. Channel c configuration is at address 0x10+8c, with the mode in bits [31:27] and the rate in bits [26:0]. Channel c pattern is at 0x14+8c. Mode 0 selects a 32-bit pattern, and a mode n in 2..31 selects an n-bit pattern. Pattern bit j%len is output during step j, starting with bit 0.
- R3: With a nonzero rate R, the output moves to the next step every R clock cycles. The first step appears one cycle after the clock edge that writes the enable bit.
- R4: With a rate of 0, a running channel holds its present output level and does not advance.
- R5: In mode 1, the output starts high and inverts at every step, so each half period lasts R cycles. The pattern word has no effect.
- R6: A write to address 0x00 loads the enable bits, with bit c controlling channel c. A disabled channel drives its output low from the second cycle after the write.
- R7: A write to address 0x04 clears every enable bit whose data bit is 1. Enable bits whose data bit is 0 are left unchanged.
- R8: Re-enabling a channel restarts it at step 0, with pattern bit 0 and a full rate period.
- R9: A new pattern or mode written while a channel runs takes effect at the next pattern wrap. The output then begins again with bit 0 of the new setting.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 8 | Write byte address |
| wr_data | input | 32 | Write data |
| pt_out | output | 3 | Registered output bit per channel |

## Verification
The hardest case to reach is an update that lands in the middle of a running pattern. The old pattern must finish exactly, and the new pattern and length must then start on the wrap step. To reach it, the bench writes a new pattern and then a shorter mode while an 8-bit sequence is partway through. It then compares every cycle against a model that switches at the wrap point.

The bench also halts a running channel by writing rate 0 and holds it there. It uses an all-ones pattern on two channels to show that a safe-disable write with a zero data bit leaves its channel running. Random lengths, rates and patterns cover the general stepping behaviour.

// File: rtl/ptg_pkg.sv
package ptg_pkg;

    localparam int NCH       = 3;
    localparam int RATE_W    = 27;
    localparam int PAT_W     = 32;
    localparam int MODE_W    = 5;
    localparam int DATA_W    = MODE_W + RATE_W;
    localparam int ADDR_W    = 8;
    localparam int IDX_W     = $clog2(PAT_W);
    localparam int CH_STRIDE = 8;

    localparam logic [ADDR_W-1:0] A_ENABLE  = 8'h00;
    localparam logic [ADDR_W-1:0] A_SAFE    = 8'h04;
    localparam logic [ADDR_W-1:0] A_CH_BASE = 8'h10;
    localparam logic [ADDR_W-1:0] PAT_OFS   = 8'h04;

    localparam logic [MODE_W-1:0] MODE_SQUARE = MODE_W'(1);

    typedef struct packed {
        logic [MODE_W-1:0] mode;
        logic [RATE_W-1:0] rate;
    } ch_cfg_t;

    typedef struct packed {
        logic             sq;
        logic [IDX_W:0]   len;
        logic [PAT_W-1:0] pat;
    } shape_t;

    function automatic shape_t shape_of(logic [MODE_W-1:0] m, logic [PAT_W-1:0] p);
        shape_t s;
        s.sq  = (m == MODE_SQUARE);
        s.len = (m == '0) ? (IDX_W+1)'(PAT_W) : (IDX_W+1)'(m);
        s.pat = p;
        return s;
    endfunction

    function automatic logic first_level(shape_t s);
        return s.sq ? 1'b1 : s.pat[0];
    endfunction

endpackage

// File: rtl/ptg_regs.sv
module ptg_regs
    import ptg_pkg::*;
#(
    parameter int N = NCH
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en_i,
    input  logic [ADDR_W-1:0]   wr_addr_i,
    input  logic [DATA_W-1:0]   wr_data_i,
    output logic [N-1:0]        en_o,
    output ch_cfg_t             cfg_o [N],
    output logic [PAT_W-1:0]    pat_o [N]
);

    logic [N-1:0] en_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q <= '0;
        end else if (wr_en_i && wr_addr_i == A_ENABLE) begin
            en_q <= wr_data_i[N-1:0];
        end else if (wr_en_i && wr_addr_i == A_SAFE) begin
            en_q <= en_q & ~wr_data_i[N-1:0];
        end
    end

    assign en_o = en_q;

    for (genvar c = 0; c < N; c++) begin : g_ch
        localparam logic [ADDR_W-1:0] CFG_A = A_CH_BASE + ADDR_W'(c * CH_STRIDE);
        localparam logic [ADDR_W-1:0] PAT_A = CFG_A + PAT_OFS;

        ch_cfg_t          cfg_r;
        logic [PAT_W-1:0] pat_r;

        always_ff @(posedge clk) begin
            if (rst) begin
                cfg_r.mode <= MODE_SQUARE;
                cfg_r.rate <= '0;
                pat_r      <= '0;
            end else if (wr_en_i) begin
                if (wr_addr_i == CFG_A) cfg_r <= ch_cfg_t'(wr_data_i);
                if (wr_addr_i == PAT_A) pat_r <= wr_data_i[PAT_W-1:0];
            end
        end

        assign cfg_o[c] = cfg_r;
        assign pat_o[c] = pat_r;
    end

    AST_SAFE_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (wr_en_i && wr_addr_i == A_SAFE) |=> ((en_q & $past(wr_data_i[N-1:0])) == '0)); // R7
    AST_SAFE_NEVER_SETS: assert property (@(posedge clk) disable iff (rst)
        (wr_en_i && wr_addr_i == A_SAFE) |=> ((en_q & ~$past(en_q)) == '0)); // R7

endmodule

// File: rtl/ptg_divider.sv
module ptg_divider
    import ptg_pkg::*;
#(
    parameter int W = RATE_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         run_i,
    input  logic         clr_i,
    input  logic [W-1:0] rate_i,
    output logic         tick_o
);

    logic [W-1:0] cnt_q;
    logic         live;

    assign live   = run_i && (rate_i != '0);
    assign tick_o = live && (cnt_q >= rate_i - 1'b1);

    always_ff @(posedge clk) begin
        if (rst || clr_i) begin
            cnt_q <= '0;
        end else if (live) begin
            cnt_q <= tick_o ? '0 : cnt_q + 1'b1;
        end
    end

    AST_TICK_RELOADS: assert property (@(posedge clk) disable iff (rst)
        (tick_o && !clr_i) |=> (cnt_q == '0)); // R3
    AST_HALT_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (run_i && rate_i == '0 && !clr_i) |=> $stable(cnt_q)); // R4

endmodule

// File: rtl/ptg_channel.sv
module ptg_channel
    import ptg_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             en_i,
    input  ch_cfg_t          cfg_i,
    input  logic [PAT_W-1:0] pat_i,
    output logic             out_o
);

    logic             run_q;
    logic             out_q;
    logic [IDX_W-1:0] idx_q;
    logic [IDX_W-1:0] idx_nx;
    shape_t           act_q;
    shape_t           nxt;
    logic             start;
    logic             tick;
    logic             wrap;

    assign start  = en_i && !run_q;
    assign nxt    = shape_of(cfg_i.mode, pat_i);
    assign idx_nx = idx_q + 1'b1;
    assign wrap   = act_q.sq || ({1'b0, idx_q} == act_q.len - 1'b1);

    ptg_divider #(.W(RATE_W)) u_div (
        .clk    (clk),
        .rst    (rst),
        .run_i  (en_i && run_q),
        .clr_i  (start),
        .rate_i (cfg_i.rate),
        .tick_o (tick)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q <= 1'b0;
            out_q <= 1'b0;
            idx_q <= '0;
            act_q <= shape_of(MODE_SQUARE, '0);
        end else if (!en_i) begin
            run_q <= 1'b0;
            out_q <= 1'b0;
        end else if (start) begin
            run_q <= 1'b1;
            idx_q <= '0;
            act_q <= nxt;
            out_q <= first_level(nxt);
        end else if (tick) begin
            if (wrap) begin
                act_q <= nxt;
                idx_q <= '0;
                out_q <= (act_q.sq && nxt.sq) ? ~out_q : first_level(nxt);
            end else begin
                idx_q <= idx_nx;
                out_q <= act_q.pat[idx_nx];
            end
        end
    end

    assign out_o = out_q;

    AST_OFF_LOW: assert property (@(posedge clk) disable iff (rst)
        !en_i |=> !out_q); // R6
    AST_IDX_RANGE: assert property (@(posedge clk) disable iff (rst)
        (run_q && !act_q.sq) |-> ({1'b0, idx_q} < act_q.len)); // R2
    AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (rst)
        $rose(run_q) |-> (idx_q == '0)); // R8
    AST_HALT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (run_q && en_i && cfg_i.rate == '0) |=> $stable(out_q)); // R4
    AST_SQUARE_FLIPS: assert property (@(posedge clk) disable iff (rst)
        (run_q && en_i && tick && act_q.sq && nxt.sq) |=> (out_q != $past(out_q))); // R5

endmodule

// File: rtl/pulse_train_gen.sv
module pulse_train_gen
    import ptg_pkg::*;
#(
    parameter int N = NCH
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [N-1:0]      pt_out
);

    logic [N-1:0]     en;
    ch_cfg_t          cfg [N];
    logic [PAT_W-1:0] pat [N];

    ptg_regs #(.N(N)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_en_i   (wr_en),
        .wr_addr_i (wr_addr),
        .wr_data_i (wr_data),
        .en_o      (en),
        .cfg_o     (cfg),
        .pat_o     (pat)
    );

    for (genvar c = 0; c < N; c++) begin : g_chan
        ptg_channel u_ch (
            .clk   (clk),
            .rst   (rst),
            .en_i  (en[c]),
            .cfg_i (cfg[c]),
            .pat_i (pat[c]),
            .out_o (pt_out[c])
        );
    end

    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> (pt_out == '0)); // R1

endmodule

// File: tb/tb_pulse_train_gen.sv
module tb_pulse_train_gen;
    import ptg_pkg::*;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              wr_en = 1'b0;
    logic [ADDR_W-1:0] wr_addr = '0;
    logic [DATA_W-1:0] wr_data = '0;
    logic [NCH-1:0]    pt_out;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    pulse_train_gen dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .pt_out(pt_out)
    );

    always #10 clk = ~clk;

    function automatic logic exp_out(logic [4:0] m, int r, logic [31:0] p, int t);
        int step = t / r;
        int len;
        if (m == 5'd1) return ((step % 2) == 0);
        len = (m == 5'd0) ? 32 : int'(m);
        return p[step % len];
    endfunction

    task automatic chk(input logic got, input logic expv, input string req, input int t);
        total++;
        if (got !== expv) begin
            bad++;
            $display("FAIL %s t=%0d got=%0b expected=%0b", req, t, got, expv);
        end
    endtask

    // called at a negedge; write edge is the next posedge; returns at the following negedge
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic setup(input int c, input logic [4:0] m, input int r, input logic [31:0] p);
        wr(8'h10 + 8'(c * 8), {m, 27'(r)});
        wr(8'h14 + 8'(c * 8), p);
    endtask

    task automatic run_check(input int c, input logic [4:0] m, input int r,
                             input logic [31:0] p, input int n, input string req);
        setup(c, m, r, p);
        wr(8'h00, 32'(1 << c));
        for (int t = 0; t < n; t++) begin
            @(negedge clk);
            chk(pt_out[c], exp_out(m, r, p, t), req, t);
        end
        chk(|(pt_out & ~NCH'(1 << c)), 1'b0, "R6 other channels", n);
        wr(8'h00, 32'h0);
        @(negedge clk);
        chk(pt_out[c], 1'b0, "R6 disabled low", 0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : stim
        int unsigned seed_v;
        logic held;
        seed_v = $urandom(32'd20240611);
        repeat (3) @(posedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        chk(|pt_out, 1'b0, "R1 outputs low", 0);
        wr(8'h00, 32'h1);
        for (int t = 0; t < 5; t++) begin
            @(negedge clk);
            chk(pt_out[0], 1'b1, "R1 default square rate0 high", t);
        end
        wr(8'h00, 32'h0);
        @(negedge clk);

        // R2 directed lengths
        run_check(0, 5'd0, 1, 32'hC3A5_0F71, 70, "R2 32-bit");
        run_check(1, 5'd31, 1, 32'h7FFF_0001, 66, "R2 31-bit");
        run_check(2, 5'd2, 3, 32'hFFFF_FFF2, 20, "R2 2-bit");
        // R3 rate spacing
        run_check(0, 5'd5, 4, 32'h0000_0016, 45, "R3 rate4");
        // R5 square, pattern ignored
        run_check(1, 5'd1, 2, 32'hAAAA_5555, 20, "R5 square rate2");
        run_check(2, 5'd1, 1, 32'h0, 10, "R5 square rate1");

        // R8: restart from bit 0
        run_check(1, 5'd8, 1, 32'h96, 5, "R8 first run");
        run_check(1, 5'd8, 1, 32'h96, 12, "R8 restart");

        // R4: halt via rate 0 mid-run
        setup(2, 5'd0, 2, 32'h5A5A_33CC);
        wr(8'h00, 32'h4);
        for (int t = 0; t < 9; t++) begin
            @(negedge clk);
            chk(pt_out[2], exp_out(5'd0, 2, 32'h5A5A_33CC, t), "R4 before halt", t);
        end
        wr(8'h20, {5'd0, 27'd0});
        held = pt_out[2];
        for (int t = 0; t < 15; t++) begin
            @(negedge clk);
            chk(pt_out[2], held, "R4 halted hold", t);
        end
        wr(8'h00, 32'h0);
        @(negedge clk);

        // R7: safe disable
        setup(0, 5'd0, 1, 32'hFFFF_FFFF);
        setup(2, 5'd0, 1, 32'hFFFF_FFFF);
        wr(8'h00, 32'h5);
        @(negedge clk);
        wr(8'h04, 32'h0);
        @(negedge clk);
        chk(pt_out[0], 1'b1, "R7 zero write keeps ch0", 0);
        chk(pt_out[2], 1'b1, "R7 zero write keeps ch2", 0);
        wr(8'h04, 32'h1);
        @(negedge clk);
        chk(pt_out[0], 1'b0, "R7 ch0 stopped", 0);
        chk(pt_out[2], 1'b1, "R7 ch2 still on", 0);
        repeat (3) @(negedge clk);
        chk(pt_out[2], 1'b1, "R7 ch2 still on later", 3);
        wr(8'h04, 32'h4);
        @(negedge clk);
        chk(|pt_out, 1'b0, "R7 all stopped", 0);

        // R9: pattern and length update at wrap
        setup(0, 5'd8, 1, 32'h0000_00B4);
        wr(8'h00, 32'h1);
        for (int t = 0; t < 3; t++) begin
            @(negedge clk);
            chk(pt_out[0], exp_out(5'd8, 1, 32'hB4, t), "R9 old pattern", t);
        end
        wr(8'h14, 32'h0000_0009);
        chk(pt_out[0], exp_out(5'd8, 1, 32'hB4, 3), "R9 old pattern", 3);
        wr(8'h10, {5'd4, 27'd1});
        chk(pt_out[0], exp_out(5'd8, 1, 32'hB4, 4), "R9 old pattern", 4);
        for (int t = 5; t < 20; t++) begin
            @(negedge clk);
            if (t < 8) chk(pt_out[0], exp_out(5'd8, 1, 32'hB4, t), "R9 old pattern", t);
            else       chk(pt_out[0], exp_out(5'd4, 1, 32'h9, t - 8), "R9 new at wrap", t);
        end
        wr(8'h00, 32'h0);
        @(negedge clk);

        // random mix (R2, R3, R5)
        for (int i = 0; i < 24; i++) begin
            int c = int'($urandom % 3);
            int r = 1 + int'($urandom % 3);
            int k = int'($urandom % 31);
            logic [4:0] m = (k == 0) ? 5'd0 : 5'(k + 1);
            logic [31:0] p = $urandom;
            int len;
            if ($urandom % 5 == 0) m = 5'd1;
            len = (m == 5'd0) ? 32 : (m == 5'd1 ? 4 : int'(m));
            run_check(c, m, r, p, len * r + 6, (m == 5'd1) ? "R5 random square" : "R3 random pattern");
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule